// File: doc/BRIEF.md
# Instruction Length and Conditional Skip Controller

This block sits in the issue stage of a small 16-bit word-addressed processor. Each accepted instruction word is split into a 4-bit opcode and two 6-bit operand selectors. The block then works out how many words the instruction occupies, evaluates the conditional-test opcodes against the operand values supplied by the operand stage, and produces the program counter of the next instruction to run.

When a conditional test fails, the following instruction is not executed. The block decodes the word that follows only to learn its length, and the next PC moves past all of its words. A call in the extended opcode group produces a push request for the return address, using a pre-decremented stack pointer. The other extended codes are flagged as illegal and have no other effect.

The caller supplies the instruction word, the first word of the instruction after it, both operand values, the PC and the SP. All results are registered and appear one cycle after `in_valid`.

Top module: `insn_seq_ctl`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `out_valid` is high and `opcode`, `field_a`, `field_b` hold instruction bits [3:0], [9:4] and [15:10]. In a cycle after one with `in_valid` low, `out_valid` is low.
- R2: `length` is 1 plus one for each counted operand selector whose value is in 0x10..0x17, or equal to 0x1E or 0x1F. It is always between 1 and 3.
- R3: An opcode of 0 marks an extended instruction. For that form, `field_a` holds the extended code and only `field_b` is counted toward the length.
- R4: `cond_ok` is `a_val == b_val` for opcode 0xC, `a_val != b_val` for 0xD, `a_val > b_val` (unsigned) for 0xE and `(a_val & b_val) != 0` for 0xF. It is 1 for every other opcode.
- R5: When a test opcode (0xC..0xF) gives `cond_ok` = 0, `skip_taken` is 1. `skip_len` is then the length of `follow_instr`, decoded by the rules of R2 and R3, and `next_pc` = `pc_in` + `length` + `skip_len`, modulo 2^16.
- R6: For any instruction that is neither a skip nor a call, `skip_taken` is 0, `skip_len` is 0 and `next_pc` = `pc_in` + `length`, modulo 2^16.
- R7: An extended instruction with code 0x01 is a call. It gives `jsr_taken` = 1, `next_pc` = `b_val`, `sp_out` = `sp_in` - 1, `push_en` = 1 and `push_data` = `pc_in` + `length`.
- R8: Any extended code other than 0x01 gives `illegal_evt` = 1, `push_en` = 0, `sp_out` = `sp_in` and `next_pc` = `pc_in` + `length`.
- R9: Apart from a call, `sp_out` equals `sp_in` and `push_en` is 0. This holds even when the skipped word selects a stack push (0x1A) or pop (0x18).
- R10: While `rst` is high and in the cycle after it, `out_valid` is low. All registered outputs are zero in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 16 | Instruction word to issue |
| follow_instr | input | 16 | First word of the instruction after it |
| a_val | input | 16 | Resolved value of operand a |
| b_val | input | 16 | Resolved value of operand b |
| pc_in | input | 16 | Address of `instr` |
| sp_in | input | 16 | Current stack pointer |
| out_valid | output | 1 | Results valid |
| opcode | output | 4 | Basic opcode field |
| field_a | output | 6 | Operand a selector or extended code |
| field_b | output | 6 | Operand b selector |
| length | output | 2 | Words in the instruction |
| cond_ok | output | 1 | Test result (1 for non-test opcodes) |
| skip_taken | output | 1 | Following instruction is skipped |
| skip_len | output | 2 | Words skipped (0 when no skip) |
| next_pc | output | 16 | Address of the next instruction to run |
| sp_out | output | 16 | Stack pointer after this instruction |
| push_en | output | 1 | Write `push_data` at address `sp_out` |
| push_data | output | 16 | Return address to push |
| jsr_taken | output | 1 | Call executed |
| illegal_evt | output | 1 | Reserved extended code seen |

## Verification
Random instruction words use selectors biased toward the ranges that add a word, so lengths of one, two and three words all occur. They are mixed with random operand values that often coincide, so each test opcode sees both outcomes. Directed cases set three-word skips against one-word skips whose skipped word pushes or pops. They also cover an extended word being skipped, where a long field a must not count, and an unsigned compare across the sign bit. Calls, reserved extended codes and PC wrap-around at 0xFFFF separate the call target, the plain advance and modulo arithmetic.

// File: rtl/insn_seq_pkg.sv
package insn_seq_pkg;
    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int OPD_W  = 6;
    localparam int LEN_W  = 2;
    localparam int A_LSB  = OPC_W;
    localparam int B_LSB  = OPC_W + OPD_W;

    localparam logic [OPC_W-1:0] OPC_EXT = '0;
    localparam logic [OPC_W-1:0] OPC_TEQ = 4'hC;
    localparam logic [OPC_W-1:0] OPC_TNE = 4'hD;
    localparam logic [OPC_W-1:0] OPC_TGT = 4'hE;
    localparam logic [OPC_W-1:0] OPC_TBT = 4'hF;
    localparam logic [OPD_W-1:0] EXT_CALL = 6'h01;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [OPD_W-1:0] fb;
        logic [OPD_W-1:0] fa;
        logic [OPC_W-1:0] opc;
    } fields_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [OPD_W-1:0] fa;
        logic [OPD_W-1:0] fb;
        logic [LEN_W-1:0] len;
        logic             cond_ok;
        logic             skip;
        logic [LEN_W-1:0] skip_len;
        word_t            next_pc;
        word_t            sp;
        logic             push;
        word_t            push_data;
        logic             call;
        logic             illegal;
    } result_t;

    function automatic fields_t split_word(word_t w);
        return fields_t'(w);
    endfunction

    // selector needs an extra word: indexed-by-register, absolute address, literal word
    function automatic logic sel_adds_word(logic [OPD_W-1:0] s);
        return (s[OPD_W-1:3] == 3'b010) || (s == 6'h1E) || (s == 6'h1F);
    endfunction

    function automatic logic is_test(logic [OPC_W-1:0] o);
        return o[OPC_W-1:OPC_W-2] == 2'b11;
    endfunction
endpackage

// File: rtl/insn_len_dec.sv
module insn_len_dec
    import insn_seq_pkg::*;
(
    input  word_t            word_in,
    output fields_t          flds,
    output logic [LEN_W-1:0] words
);
    logic ext_form;
    logic cnt_a;
    logic cnt_b;

    always_comb begin
        flds     = split_word(word_in);
        ext_form = (flds.opc == OPC_EXT);
        cnt_b    = sel_adds_word(flds.fb);
        cnt_a    = !ext_form && sel_adds_word(flds.fa);
        words    = LEN_W'(1) + LEN_W'(cnt_a) + LEN_W'(cnt_b);
    end
endmodule

// File: rtl/insn_cond_eval.sv
module insn_cond_eval
    import insn_seq_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  word_t            lhs,
    input  word_t            rhs,
    output logic             pass
);
    always_comb begin
        unique case (opc)
            OPC_TEQ: pass = (lhs == rhs);
            OPC_TNE: pass = (lhs != rhs);
            OPC_TGT: pass = (lhs > rhs);
            OPC_TBT: pass = |(lhs & rhs);
            default: pass = 1'b1;
        endcase
    end
endmodule

// File: rtl/insn_flow_calc.sv
module insn_flow_calc
    import insn_seq_pkg::*;
(
    input  fields_t          flds,
    input  logic [LEN_W-1:0] cur_len,
    input  logic [LEN_W-1:0] nxt_len,
    input  logic             pass,
    input  word_t            pc,
    input  word_t            sp,
    input  word_t            target,
    output result_t          res
);
    logic  ext_form;
    word_t ret_pc;

    always_comb begin
        ext_form      = (flds.opc == OPC_EXT);
        ret_pc        = pc + WORD_W'(cur_len);
        res           = '0;
        res.opc       = flds.opc;
        res.fa        = flds.fa;
        res.fb        = flds.fb;
        res.len       = cur_len;
        res.cond_ok   = pass;
        res.call      = ext_form && (flds.fa == EXT_CALL);
        res.illegal   = ext_form && (flds.fa != EXT_CALL);
        res.skip      = is_test(flds.opc) && !pass;
        res.skip_len  = res.skip ? nxt_len : '0;
        res.sp        = res.call ? sp - WORD_W'(1) : sp;
        res.push      = res.call;
        res.push_data = res.call ? ret_pc : '0;
        res.next_pc   = res.call ? target : ret_pc + WORD_W'(res.skip_len);
    end
endmodule

// File: rtl/insn_seq_ctl.sv
module insn_seq_ctl
    import insn_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [15:0]       instr,
    input  logic [15:0]       follow_instr,
    input  logic [15:0]       a_val,
    input  logic [15:0]       b_val,
    input  logic [15:0]       pc_in,
    input  logic [15:0]       sp_in,
    output logic              out_valid,
    output logic [3:0]        opcode,
    output logic [5:0]        field_a,
    output logic [5:0]        field_b,
    output logic [1:0]        length,
    output logic              cond_ok,
    output logic              skip_taken,
    output logic [1:0]        skip_len,
    output logic [15:0]       next_pc,
    output logic [15:0]       sp_out,
    output logic              push_en,
    output logic [15:0]       push_data,
    output logic              jsr_taken,
    output logic              illegal_evt
);
    localparam int NSLOT = 2;

    word_t            slot_word [NSLOT];
    fields_t          slot_flds [NSLOT];
    logic [LEN_W-1:0] slot_len  [NSLOT];

    assign slot_word[0] = instr;
    assign slot_word[1] = follow_instr;

    for (genvar g = 0; g < NSLOT; g++) begin : g_len
        insn_len_dec u_len (
            .word_in (slot_word[g]),
            .flds    (slot_flds[g]),
            .words   (slot_len[g])
        );
    end

    logic pass;

    insn_cond_eval u_cond (
        .opc  (slot_flds[0].opc),
        .lhs  (a_val),
        .rhs  (b_val),
        .pass (pass)
    );

    result_t res_d, res_q;
    logic    vld_q;

    insn_flow_calc u_flow (
        .flds    (slot_flds[0]),
        .cur_len (slot_len[0]),
        .nxt_len (slot_len[1]),
        .pass    (pass),
        .pc      (pc_in),
        .sp      (sp_in),
        .target  (b_val),
        .res     (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            res_q <= in_valid ? res_d : '0;
        end
    end

    assign out_valid   = vld_q;
    assign opcode      = res_q.opc;
    assign field_a     = res_q.fa;
    assign field_b     = res_q.fb;
    assign length      = res_q.len;
    assign cond_ok     = res_q.cond_ok;
    assign skip_taken  = res_q.skip;
    assign skip_len    = res_q.skip_len;
    assign next_pc     = res_q.next_pc;
    assign sp_out      = res_q.sp;
    assign push_en     = res_q.push;
    assign push_data   = res_q.push_data;
    assign jsr_taken   = res_q.call;
    assign illegal_evt = res_q.illegal;
endmodule

// File: rtl/insn_seq_chk.sv
module insn_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [15:0] pc_in,
    input logic [15:0] sp_in,
    input logic [15:0] b_val,
    input logic        out_valid,
    input logic [3:0]  opcode,
    input logic [1:0]  length,
    input logic        cond_ok,
    input logic        skip_taken,
    input logic [15:0] next_pc,
    input logic [15:0] sp_out,
    input logic        push_en,
    input logic        jsr_taken,
    input logic        illegal_evt
);
    a_r1_valid_tracks_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    a_r2_length_nonzero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (length != 2'd0));

    a_r5_skip_needs_failed_test: assert property (@(posedge clk) disable iff (rst)
        skip_taken |-> (opcode[3:2] == 2'b11) && !cond_ok);

    a_r7_call_target: assert property (@(posedge clk) disable iff (rst)
        jsr_taken |-> (next_pc == $past(b_val)) && push_en
                      && (sp_out == $past(sp_in) - 16'd1));

    a_r8_reserved_advance: assert property (@(posedge clk) disable iff (rst)
        illegal_evt |-> !push_en && !jsr_taken
                        && (next_pc == $past(pc_in) + {14'd0, length}));

    a_r9_stack_held: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !jsr_taken) |-> (sp_out == $past(sp_in)) && !push_en);

    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !push_en);
endmodule

bind insn_seq_ctl insn_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .pc_in       (pc_in),
    .sp_in       (sp_in),
    .b_val       (b_val),
    .out_valid   (out_valid),
    .opcode      (opcode),
    .length      (length),
    .cond_ok     (cond_ok),
    .skip_taken  (skip_taken),
    .next_pc     (next_pc),
    .sp_out      (sp_out),
    .push_en     (push_en),
    .jsr_taken   (jsr_taken),
    .illegal_evt (illegal_evt)
);

// File: tb/insn_seq_ctl_tb.sv
module insn_seq_ctl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0, follow_instr = '0, a_val = '0, b_val = '0;
    logic [15:0] pc_in = '0, sp_in = '0;
    logic        out_valid, cond_ok, skip_taken, push_en, jsr_taken, illegal_evt;
    logic [3:0]  opcode;
    logic [5:0]  field_a, field_b;
    logic [1:0]  length, skip_len;
    logic [15:0] next_pc, sp_out, push_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    insn_seq_ctl u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .follow_instr(follow_instr), .a_val(a_val), .b_val(b_val),
        .pc_in(pc_in), .sp_in(sp_in), .out_valid(out_valid),
        .opcode(opcode), .field_a(field_a), .field_b(field_b),
        .length(length), .cond_ok(cond_ok), .skip_taken(skip_taken),
        .skip_len(skip_len), .next_pc(next_pc), .sp_out(sp_out),
        .push_en(push_en), .push_data(push_data), .jsr_taken(jsr_taken),
        .illegal_evt(illegal_evt)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (instr=%h follow=%h)",
                     req, act, exp, instr, follow_instr);
        end
    endtask

    // bench-side model of the rules
    function automatic int extra(int sel);
        if (sel >= 16 && sel <= 23) return 1;
        if (sel == 30 || sel == 31) return 1;
        return 0;
    endfunction

    function automatic int words_of(logic [15:0] w);
        int op = w & 16'hF;
        int sa = (w >> 4) & 16'h3F;
        int sb = (w >> 10) & 16'h3F;
        return 1 + extra(sb) + ((op != 0) ? extra(sa) : 0);
    endfunction

    function automatic bit test_ok(int op, logic [15:0] x, logic [15:0] y);
        case (op)
            12: return x == y;
            13: return x != y;
            14: return x > y;
            15: return (x & y) != 16'd0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] mk(int op, int sa, int sb);
        return 16'((sb << 10) | (sa << 4) | op);
    endfunction

    function automatic int rnd_sel();
        int k = int'($urandom_range(0, 3));
        if (k == 0) return int'($urandom_range(16, 23));
        if (k == 1) return 30 + int'($urandom_range(0, 1));
        return int'($urandom_range(0, 63));
    endfunction

    task automatic run_one(logic [15:0] w, logic [15:0] fw, logic [15:0] av,
                           logic [15:0] bv, logic [15:0] pc, logic [15:0] sp);
        int op, sa, sb, len, flen, sk;
        bit ok, ext, call;
        logic [15:0] exp_pc;
        @(negedge clk);
        instr = w; follow_instr = fw; a_val = av; b_val = bv;
        pc_in = pc; sp_in = sp; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        op = w & 16'hF; sa = (w >> 4) & 16'h3F; sb = (w >> 10) & 16'h3F;
        len  = words_of(w);
        flen = words_of(fw);
        ext  = (op == 0);
        call = ext && (sa == 1);
        ok   = test_ok(op, av, bv);
        sk   = (op >= 12 && !ok) ? flen : 0;
        exp_pc = call ? bv : 16'(pc + len + sk);
        chk("R1 out_valid", out_valid, 1);
        chk("R1 opcode",  opcode,  op);
        chk("R1 field_a", field_a, sa);
        chk("R1 field_b", field_b, sb);
        chk(ext ? "R3 length" : "R2 length", length, len);
        chk("R4 cond_ok", cond_ok, ok);
        chk("R5 skip_taken", skip_taken, sk != 0);
        chk("R5 skip_len", skip_len, sk);
        chk(call ? "R7 next_pc" : (sk != 0 ? "R5 next_pc" : "R6 next_pc"), next_pc, exp_pc);
        chk(call ? "R7 sp_out" : "R9 sp_out", sp_out, call ? 16'(sp - 1) : sp);
        chk(call ? "R7 push_en" : "R9 push_en", push_en, call);
        if (call) chk("R7 push_data", push_data, 16'(pc + len));
        chk("R7 jsr_taken", jsr_taken, call);
        chk("R8 illegal_evt", illegal_evt, ext && !call);
    endtask

    initial begin
        void'($urandom(32'h5EED_0C1A));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: registered outputs quiet during reset
        chk("R10 out_valid", out_valid, 0);
        chk("R10 next_pc", next_pc, 0);
        chk("R10 push_en", push_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 out_valid after release", out_valid, 0);

        // R5 three-word skip, equal test fails on IFN
        run_one(mk(13, 0, 1), mk(2, 30, 31), 16'h1234, 16'h1234, 16'h0100, 16'hFF00);
        // R9 one-word skip over push/pop word
        run_one(mk(12, 0, 1), mk(1, 26, 24), 16'h0001, 16'h0002, 16'h0200, 16'h8000);
        // R3 skipped extended word: field a not counted
        run_one(mk(15, 0, 1), mk(0, 31, 0), 16'h00F0, 16'h000F, 16'h0300, 16'h1000);
        // R3 skipped extended word with counted b
        run_one(mk(14, 0, 1), mk(0, 1, 17), 16'h0001, 16'h0001, 16'h0310, 16'h1000);
        // R4 unsigned compare across sign bit
        run_one(mk(14, 0, 1), mk(1, 0, 0), 16'h8000, 16'h7FFF, 16'h0400, 16'h1000);
        run_one(mk(14, 0, 1), mk(1, 0, 0), 16'h7FFF, 16'h8000, 16'h0400, 16'h1000);
        // R7 call with literal word operand
        run_one(mk(0, 1, 31), mk(1, 0, 0), 16'h0000, 16'h4321, 16'h0500, 16'h0000);
        // R8 reserved extended codes
        run_one(mk(0, 0, 30), mk(1, 0, 0), 16'h0000, 16'h9999, 16'h0600, 16'h2222);
        run_one(mk(0, 2, 3),  mk(1, 0, 0), 16'h0000, 16'h9999, 16'h0610, 16'h2222);
        // R6 wrap-around at top of address space, three-word instruction
        run_one(mk(2, 16, 31), mk(1, 0, 0), 16'h0001, 16'h0002, 16'hFFFF, 16'h3333);
        // R5 skip that wraps
        run_one(mk(12, 0, 1), mk(3, 23, 30), 16'h0001, 16'h0000, 16'hFFFE, 16'h3333);

        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom_range(0, 15));
            int sa = (op == 0 && $urandom_range(0, 1) == 1) ? 1 : rnd_sel();
            logic [15:0] av = 16'($urandom);
            logic [15:0] bv = ($urandom_range(0, 2) == 0) ? av : 16'($urandom);
            run_one(mk(op, sa, rnd_sel()), mk(int'($urandom_range(0, 15)), rnd_sel(), rnd_sel()),
                    av, bv, 16'($urandom), 16'($urandom));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule